// File: doc/BRIEF.md
# Packed Instruction Slot Sequencer

This block feeds an execution unit from a small local program store in which every 18-bit word carries four opcodes. It fetches one word at a time over a request/acknowledge handshake. It then issues the packed opcodes one per step, in order, as a 5-bit opcode with a valid strobe. No opcode has an operand field. The first three slots are full 5-bit fields. The fourth slot is only 3 bits wide and is widened to an opcode whose two low bits are zero, so only 8 of the 32 opcodes can be placed last in a word.

The execution side can hold the sequencer with a stall input. It can also redirect it with a transfer input and a 7-bit target word address, which covers both 64-word halves of the store. A transfer discards the slots that remain in the current word. Fetch addresses step by one word for each word accepted and wrap at the top of the 7-bit space.

Top module: `pss_seq`

## Requirements
- R1: Slots 0, 1 and 2 are taken from word bits [17:13], [12:8] and [7:3] and are issued in that order on consecutive unstalled steps.
- R2: Slot 3 is taken from bits [2:0] and is issued fourth as the 5-bit opcode {bits[2:0], 2'b00}.
- R3: Each accepted word advances fetch_addr by one, and the address wraps from 127 to 0.
- R4: While rst is high, op_valid is 0, fetch_addr is 0 and fetch_req is 1.
- R5: While stall is high, the next cycle shows op_out and op_valid unchanged, and no slot is consumed.
- R6: When xfer is high with op_valid high and stall low, the next cycle has op_valid 0 and fetch_addr equal to xfer_tgt, and the unissued slots of that word are never issued.
- R7: A word is accepted at a clock edge where fetch_req and fetch_ack are both high. fetch_req is high exactly when no slots remain. Its first slot is valid one cycle after acceptance, and op_valid is 0 (if not stalled) while a fetch is waiting.
- R8: A fetch_ack in the same cycle as an accepted transfer is discarded, and fetch_req stays high for the target.
- R9: fetch_ack while fetch_req is low has no effect on fetch_addr or on the slots issued.
- R10: xfer has no effect while op_valid is low or stall is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | output | 1 | Word wanted from program store |
| fetch_addr | output | 7 | Word address to read |
| fetch_ack | input | 1 | fetch_data is valid this cycle |
| fetch_data | input | 18 | Packed instruction word |
| stall | input | 1 | Hold the issue stage |
| xfer | input | 1 | Current opcode transfers control |
| xfer_tgt | input | 7 | Word address to continue from |
| op_out | output | 5 | Issued opcode |
| op_valid | output | 1 | op_out is a new issue |

## Verification
Every output of the block is a register, so each result is due exactly one clock edge after the inputs that cause it: an opcode one edge after its word is accepted or the previous slot is consumed, a new fetch address one edge after an acceptance or a transfer. The bench drives inputs on the falling edge. A behavioural model updates on the rising edge from the same inputs, and the outputs are compared on the next falling edge, which lines each check up with that single register delay. Fetch latency, stalls and transfers are varied per phase. The timing of the model does not depend on any of them.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int DEF_WORD_W = 18;
  localparam int DEF_SLOT_W = 5;
  localparam int DEF_LAST_W = 3;
  localparam int DEF_SLOTS  = 4;
  localparam int DEF_ADDR_W = 7;
endpackage

// File: rtl/pss_slot_pick.sv
module pss_slot_pick #(
  parameter int WORD_W = 18,
  parameter int SLOT_W = 5,
  parameter int LAST_W = 3,
  parameter int SLOTS  = 4,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  output logic [SLOT_W-1:0] op
);
  localparam int PAD_W = SLOT_W - LAST_W;

  logic [SLOT_W-1:0] field [SLOTS];

  for (genvar g = 0; g < SLOTS - 1; g++) begin : g_full
    assign field[g] = word[WORD_W-1-g*SLOT_W -: SLOT_W];
  end
  // short last slot: widen with zeros on the low side
  assign field[SLOTS-1] = {word[LAST_W-1:0], {PAD_W{1'b0}}};

  assign op = field[idx];
endmodule

// File: rtl/pss_pc.sv
module pss_pc #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              load,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (load) pc <= target;
    else if (step) pc <= pc + ADDR_W'(1);
  end
endmodule

// File: rtl/pss_word_buf.sv
module pss_word_buf #(
  parameter int WORD_W = 18,
  parameter int SLOTS  = 4,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              accept,
  input  logic              consume,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] word,
  output logic              full,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      full <= 1'b0;
      idx  <= '0;
    end else if (flush) begin
      full <= 1'b0;
      idx  <= '0;
    end else if (accept) begin
      word <= din;
      full <= 1'b1;
      idx  <= '0;
    end else if (consume) begin
      if (idx == LAST_IDX) begin
        full <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/pss_seq.sv
module pss_seq
  import pss_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int SLOT_W = DEF_SLOT_W,
  parameter int LAST_W = DEF_LAST_W,
  parameter int SLOTS  = DEF_SLOTS,
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_ack,
  input  logic [WORD_W-1:0] fetch_data,
  input  logic              stall,
  input  logic              xfer,
  input  logic [ADDR_W-1:0] xfer_tgt,
  output logic [SLOT_W-1:0] op_out,
  output logic              op_valid
);
  localparam int IDX_W = $clog2(SLOTS);

  logic              take, accept, consume, full;
  logic [WORD_W-1:0] word;
  logic [IDX_W-1:0]  idx;
  logic [SLOT_W-1:0] picked;

  assign fetch_req = ~full;
  assign take      = op_valid & xfer & ~stall;
  assign accept    = fetch_req & fetch_ack & ~take;
  assign consume   = full & ~stall & ~take;

  pss_word_buf #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_buf (
    .clk(clk), .rst(rst), .flush(take), .accept(accept), .consume(consume),
    .din(fetch_data), .word(word), .full(full), .idx(idx)
  );

  pss_slot_pick #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .LAST_W(LAST_W),
                  .SLOTS(SLOTS)) u_pick (
    .word(word), .idx(idx), .op(picked)
  );

  pss_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk(clk), .rst(rst), .step(accept), .load(take), .target(xfer_tgt),
    .pc(fetch_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_out   <= '0;
      op_valid <= 1'b0;
    end else if (take) begin
      op_valid <= 1'b0;
    end else if (!stall) begin
      op_valid <= full;
      if (full) op_out <= picked;
    end
  end
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int SLOT_W = 5,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              fetch_ack,
  input logic              stall,
  input logic              xfer,
  input logic [ADDR_W-1:0] xfer_tgt,
  input logic [SLOT_W-1:0] op_out,
  input logic              op_valid
);
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(op_out) && $stable(op_valid)));

  p_xfer_load_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer && op_valid && !stall) |=> (!op_valid && fetch_addr == $past(xfer_tgt)));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_ack && !(xfer && op_valid && !stall))
      |=> (fetch_addr == $past(fetch_addr) + ADDR_W'(1)));

  p_wait_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !fetch_ack && !stall) |=> !op_valid);

  p_ack_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_ack && xfer && op_valid && !stall) |=> (fetch_req && !op_valid));

  p_ack_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (!fetch_req && !(xfer && op_valid && !stall)) |=> $stable(fetch_addr));

  p_xfer_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (xfer && !op_valid && !fetch_req) |=> $stable(fetch_addr));
endmodule

bind pss_seq pss_checker #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
  .fetch_ack(fetch_ack), .stall(stall), .xfer(xfer), .xfer_tgt(xfer_tgt),
  .op_out(op_out), .op_valid(op_valid)
);

// File: tb/sim_pss_seq.sv
module sim_pss_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_req, fetch_ack = 1'b0, stall = 1'b0, xfer = 1'b0, op_valid;
  logic [6:0]  fetch_addr, xfer_tgt = '0;
  logic [17:0] fetch_data;
  logic [4:0]  op_out;

  always #5 clk = ~clk;

  logic [17:0] mem [128];
  assign fetch_data = mem[fetch_addr];

  pss_seq u0 (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ack(fetch_ack), .fetch_data(fetch_data), .stall(stall), .xfer(xfer),
    .xfer_tgt(xfer_tgt), .op_out(op_out), .op_valid(op_valid)
  );

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R7";

  // reference model: queue of pending opcodes, 100 added marks a last-slot opcode
  int q[$];
  int m_pc = 0, m_op = 0, m_last = 0;
  bit m_valid = 0;

  function automatic logic [17:0] pack(int a, int b, int c, int d);
    return {a[4:0], b[4:0], c[4:0], d[2:0]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_pc = 0; m_valid = 0;
    end else if (m_valid && xfer && !stall) begin
      m_valid = 0; q.delete(); m_pc = xfer_tgt;
    end else if (q.size() == 0) begin
      if (!stall) m_valid = 0;
      if (fetch_ack) begin
        for (int s = 0; s < 3; s++) q.push_back((mem[m_pc] >> (13 - 5*s)) & 31);
        q.push_back(100 + (mem[m_pc] & 7) * 4);
        m_pc = (m_pc + 1) % 128;
      end
    end else if (!stall) begin
      int e;
      e = q.pop_front();
      m_op = e % 100; m_last = e / 100; m_valid = 1;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  int amode = 0, smode = 0, xmode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int cap[4];
  int ncap = 0;

  task automatic run(int n, int a, int s, int x, string t);
    amode = a; smode = s; xmode = x; tag = t;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycles++;
      chk(op_valid == m_valid, tag, op_valid, m_valid);
      chk(fetch_req == (q.size() == 0), "R7", fetch_req, q.size() == 0);
      chk(fetch_addr == m_pc, (tag == "R7") ? "R3" : tag, fetch_addr, m_pc);
      if (m_valid) begin
        chk(op_out == m_op, m_last ? "R2" : "R1", op_out, m_op);
        if (ncap < 4) begin cap[ncap] = op_out; ncap++; end
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (amode)
        0: fetch_ack = fetch_req;
        1: fetch_ack = fetch_req && lfsr[3];
        default: fetch_ack = 1'b1;   // R9: ack also while no request
      endcase
      stall = (smode != 0) && lfsr[5] && lfsr[9];
      case (xmode)
        1: xfer = op_valid && (op_out[4:2] == 3'b111);
        2: xfer = lfsr[7];           // R10: often while op_valid low or stalled
        default: xfer = 1'b0;
      endcase
      xfer_tgt = lfsr[14:8];
    end
  endtask

  initial begin
    mem[0] = pack(1, 2, 3, 5);
    for (int i = 1; i < 128; i++) mem[i] = 18'((i * 40503 + 977) ^ (i * i * 13));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(op_valid == 1'b0, "R4", op_valid, 0);
    chk(fetch_addr == 7'd0, "R4", fetch_addr, 0);
    chk(fetch_req == 1'b1, "R4", fetch_req, 1);
    rst = 1'b0;
    run(3000, 0, 0, 0, "R7");        // R1 R2 R3 R7: plain streaming with wrap
    chk(cap[0] == 1, "R1", cap[0], 1);
    chk(cap[1] == 2, "R1", cap[1], 2);
    chk(cap[2] == 3, "R1", cap[2], 3);
    chk(cap[3] == 20, "R2", cap[3], 20);
    run(3000, 1, 1, 0, "R5");        // stalls with variable fetch latency
    run(3000, 2, 0, 0, "R9");        // acknowledge held high
    run(3000, 2, 1, 1, "R6");        // transfers, R8 when ack coincides
    run(3000, 1, 1, 2, "R10");       // transfers asserted at arbitrary times
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired after %0d cycles", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule